// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a low-frequency, always-on clock domain. A free-running counter advances on every clock when its enable conditions hold. A selectable 16-bit slice of that counter is compared against a programmable threshold. Reaching the threshold latches an interrupt flag and, if enabled, a sticky system-reset request. Software keeps the system alive by writing a feed value that restarts the count.

All changes to the configuration, count, compare and feed registers are guarded by a one-shot key. A write of the 24-bit key to the key register opens the lock. The next write to any guarded register is accepted and closes the lock again. Guarded writes made while the lock is closed are dropped. The lock is a two-state machine: `LK_SHUT` (after reset) moves to `LK_OPEN` on the *unlock* transition, which is a key-register write whose low 24 bits match. `LK_OPEN` returns to `LK_SHUT` on the *consume* transition, which is any write to a guarded register. Every other cycle is a *hold* transition. Counting can run unconditionally, or only while the core is out of reset, as reported by the wakeup sequencer.

The register interface is a single-cycle write port plus a combinational read of the addressed register. Addresses are: 0 configuration, 1 count, 2 scaled count (read only), 3 feed, 4 key, 5 compare.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the count, configuration and interrupt flag read 0, the compare register reads 0xFFFF, the key register reads 0, and `irq` and `reset_req` are low.
- R2: A write to address 4 whose bits [23:0] equal 0x51F15E opens the lock, regardless of bits [31:24]. Any other key value leaves it shut. Address 4 reads 1 while open and 0 while shut.
- R3: While shut, writes to configuration (0), count (1), feed (3) and compare (5) change nothing.
- R4: While open, one write to a guarded register takes effect and shuts the lock, so a second write without a new key is dropped.
- R5: The count (address 1) is 31 bits wide and can be read and written; read bit 31 is always 0.
- R6: Configuration bit 12 (always-run) makes the count rise by one per clock.
- R7: Configuration bit 13 (run-while-awake) makes the count rise by one per clock only while `core_in_reset` is low.
- R8: Configuration bits [3:0] give a scale s. The scaled count at address 2 is count bits [s+15:s].
- R9: When the scaled count is at or above the compare value, the interrupt flag (configuration bit 28, driving `irq`) is set on the next clock. A guarded configuration write loads the flag from bit 28, so writing 0 clears it.
- R10: With configuration bit 8 (reset enable) set, a threshold match raises `reset_req` on the next clock, and it stays high until reset.
- R11: With configuration bit 9 (zero-on-match) set, a threshold match clears the count on the next clock.
- R12: A guarded write of 0x0FEEDC0D to the feed register clears the count. Any other feed value leaves the count unchanged, but it still shuts the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_in_reset | input | 1 | High while the core is held in reset (asleep) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Interrupt, mirrors the interrupt flag |
| reset_req | output | 1 | Sticky system-reset request |

## Verification
The hardest situation to reach from the ports is a threshold match. Counting up to a 16-bit window of a 31-bit counter would take far too many slow clocks. The stimulus therefore loads the count directly through a keyed write, sets a small compare value, and steps a single clock. This lands exactly one cycle before the match is registered. The sticky reset request can only be cleared by reset, so the bench pulses reset between scenarios that would otherwise leave it or the flag set.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_state_e;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SCALED = 3'd2;
    localparam logic [ADDR_W-1:0] A_FEED   = 3'd3;
    localparam logic [ADDR_W-1:0] A_KEY    = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd5;

    localparam int unsigned B_RST_EN = 8;
    localparam int unsigned B_ZERO   = 9;
    localparam int unsigned B_ALWAYS = 12;
    localparam int unsigned B_AWAKE  = 13;
    localparam int unsigned B_IP     = 28;

endpackage

// File: rtl/wdt_keylock.sv
module wdt_keylock
    import keyed_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_ni,
    input  logic key_hit,
    input  logic prot_wr,
    output logic unlocked
);

    lock_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_SHUT: if (key_hit) st_d = LK_OPEN;
            LK_OPEN: if (prot_wr) st_d = LK_SHUT;
            default: st_d = LK_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) st_q <= LK_SHUT;
        else         st_q <= st_d;
    end

    always_comb begin
        unlocked = (st_q == LK_OPEN);
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W   = 31,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_ni,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               feed,
    input  logic               zero_cmp,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    input  logic [CMP_W-1:0]   cmp,
    output logic [CNT_W-1:0]   cnt,
    output logic [CMP_W-1:0]   scaled,
    output logic               match
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] shifted;

    always_comb begin
        shifted = cnt >> scale;
        scaled  = shifted[CMP_W-1:0];
        match   = (scaled >= cmp);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (feed || (match && zero_cmp)) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned       CNT_W      = 31,
    parameter int unsigned       CMP_W      = 16,
    parameter int unsigned       SCALE_W    = 4,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       KEY_W      = 24,
    parameter logic [KEY_W-1:0]  KEY_VALUE  = 24'h51F15E,
    parameter logic [DATA_W-1:0] FEED_VALUE = 32'h0FEEDC0D
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              core_in_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              reset_req
);

    logic               unlocked;
    logic               guarded, prot_wr, key_hit;
    logic               cfg_wr, cnt_wr, feed_ok, cmp_wr;
    logic               run, match;
    logic [SCALE_W-1:0] scale;
    logic               rst_en, zero_cmp, en_always, en_awake, ip;
    logic [CMP_W-1:0]   cmp_q;
    logic               rst_q;
    logic [CNT_W-1:0]   cnt;
    logic [CMP_W-1:0]   scaled;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        guarded = (addr == A_CFG) || (addr == A_COUNT) ||
                  (addr == A_FEED) || (addr == A_CMP);
        prot_wr = wr_en && unlocked && guarded;
        key_hit = wr_en && (addr == A_KEY) && (wdata[KEY_W-1:0] == KEY_VALUE);
        cfg_wr  = prot_wr && (addr == A_CFG);
        cnt_wr  = prot_wr && (addr == A_COUNT);
        cmp_wr  = prot_wr && (addr == A_CMP);
        feed_ok = prot_wr && (addr == A_FEED) && (wdata == FEED_VALUE);
        run     = en_always || (en_awake && !core_in_reset);
    end

    wdt_keylock u_lock (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .key_hit  (key_hit),
        .prot_wr  (prot_wr),
        .unlocked (unlocked)
    );

    wdt_counter #(
        .CNT_W   (CNT_W),
        .CMP_W   (CMP_W),
        .SCALE_W (SCALE_W)
    ) u_cnt (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .load     (cnt_wr),
        .load_val (wdata[CNT_W-1:0]),
        .feed     (feed_ok),
        .zero_cmp (zero_cmp),
        .run      (run),
        .scale    (scale),
        .cmp      (cmp_q),
        .cnt      (cnt),
        .scaled   (scaled),
        .match    (match)
    );

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            scale     <= '0;
            rst_en    <= 1'b0;
            zero_cmp  <= 1'b0;
            en_always <= 1'b0;
            en_awake  <= 1'b0;
            ip        <= 1'b0;
        end else if (cfg_wr) begin
            scale     <= wdata[SCALE_W-1:0];
            rst_en    <= wdata[B_RST_EN];
            zero_cmp  <= wdata[B_ZERO];
            en_always <= wdata[B_ALWAYS];
            en_awake  <= wdata[B_AWAKE];
            ip        <= wdata[B_IP];
        end else if (match) begin
            ip        <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)     cmp_q <= '1;
        else if (cmp_wr) cmp_q <= wdata[CMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)               rst_q <= 1'b0;
        else if (match && rst_en)  rst_q <= 1'b1;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG: begin
                rdata[SCALE_W-1:0] = scale;
                rdata[B_RST_EN]    = rst_en;
                rdata[B_ZERO]      = zero_cmp;
                rdata[B_ALWAYS]    = en_always;
                rdata[B_AWAKE]     = en_awake;
                rdata[B_IP]        = ip;
            end
            A_COUNT:  rdata[CNT_W-1:0] = cnt;
            A_SCALED: rdata[CMP_W-1:0] = scaled;
            A_KEY:    rdata[0]         = unlocked;
            A_CMP:    rdata[CMP_W-1:0] = cmp_q;
            default:  rdata            = '0;
        endcase
    end

    assign irq       = ip;
    assign reset_req = rst_q;

endmodule

// File: rtl/keyed_wdt_checker.sv
module keyed_wdt_checker
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned CNT_W  = 31,
    parameter int unsigned CMP_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_ni,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              reset_req,
    input logic              unlocked,
    input logic [CMP_W-1:0]  cmp_q,
    input logic              match,
    input logic              zero_cmp,
    input logic [CNT_W-1:0]  cnt
);

    logic grd;
    assign grd = (addr == A_CFG) || (addr == A_COUNT) ||
                 (addr == A_FEED) || (addr == A_CMP);

    p_locked_cmp_r3: assert property (@(posedge clk) disable iff (!rst_ni)
        (!unlocked && wr_en && addr == A_CMP) |=> $stable(cmp_q));

    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_ni)
        (unlocked && wr_en && grd) |=> !unlocked);

    p_count_msb_r5: assert property (@(posedge clk) disable iff (!rst_ni)
        (addr == A_COUNT) |-> (rdata[DATA_W-1] == 1'b0));

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_ni)
        (match && !(unlocked && wr_en && addr == A_CFG)) |=> irq);

    p_reset_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
        reset_req |=> reset_req);

    p_zero_on_match_r11: assert property (@(posedge clk) disable iff (!rst_ni)
        (match && zero_cmp && !(unlocked && wr_en && addr == A_COUNT)) |=> (cnt == '0));

endmodule

bind keyed_wdt keyed_wdt_checker #(
    .CNT_W  (CNT_W),
    .CMP_W  (CMP_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .irq       (irq),
    .reset_req (reset_req),
    .unlocked  (unlocked),
    .cmp_q     (cmp_q),
    .match     (match),
    .zero_cmp  (zero_cmp),
    .cnt       (cnt)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;

    localparam logic [2:0] A_CFG = 3'd0, A_COUNT = 3'd1, A_SCALED = 3'd2,
                           A_FEED = 3'd3, A_KEY = 3'd4, A_CMP = 3'd5;
    localparam logic [31:0] KEY  = 32'h0051F15E;
    localparam logic [31:0] FEED = 32'h0FEEDC0D;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        core_in_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq, reset_req;

    always #5 clk = ~clk;

    keyed_wdt uut (
        .clk           (clk),
        .rst_ni        (rst_ni),
        .core_in_reset (core_in_reset),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .irq           (irq),
        .reset_req     (reset_req)
    );

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  smp;
    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = (it.sel == 0) ? rdata :
                      (it.sel == 1) ? {31'd0, irq} : {31'd0, reset_req};
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input string tag, input int sel, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        q.push_back(it);
        -> smp;
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock_wr(input logic [2:0] a, input logic [31:0] d);
        wr(A_KEY, KEY);
        wr(a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a; #1;
        expect_item(tag, 0, exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic count_delta(input string tag, input int k, input int exp_rise);
        logic [31:0] base;
        addr = A_COUNT; #1;
        base = rdata;
        repeat (k) @(posedge clk);
        @(negedge clk);
        rd_chk(tag, A_COUNT, base + exp_rise);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1 reset state
        rd_chk("R1 cfg", A_CFG, 32'h0);
        rd_chk("R1 count", A_COUNT, 32'h0);
        rd_chk("R1 cmp", A_CMP, 32'h0000FFFF);
        rd_chk("R1 key", A_KEY, 32'h0);
        expect_item("R1 irq", 1, 32'h0);
        expect_item("R1 reset_req", 2, 32'h0);

        // R3 locked writes dropped
        wr(A_CMP, 32'h1234);
        rd_chk("R3 cmp locked", A_CMP, 32'h0000FFFF);
        wr(A_COUNT, 32'h55);
        rd_chk("R3 count locked", A_COUNT, 32'h0);
        wr(A_CFG, 32'h1000);
        rd_chk("R3 cfg locked", A_CFG, 32'h0);
        wr(A_FEED, FEED);
        rd_chk("R3 feed locked", A_COUNT, 32'h0);

        // R2 key handling
        wr(A_KEY, 32'h00AAAAAA);
        rd_chk("R2 wrong key", A_KEY, 32'h0);
        wr(A_KEY, 32'hFF51F15E);
        rd_chk("R2 key opens", A_KEY, 32'h1);

        // R4 one-shot
        wr(A_CMP, 32'h0100);
        rd_chk("R4 first write", A_CMP, 32'h0100);
        rd_chk("R4 relocked", A_KEY, 32'h0);
        wr(A_CMP, 32'h0200);
        rd_chk("R4 second write dropped", A_CMP, 32'h0100);

        // R5 count width
        unlock_wr(A_COUNT, 32'hFFFFFFFF);
        rd_chk("R5 count msb", A_COUNT, 32'h7FFFFFFF);

        // R12 feed
        unlock_wr(A_FEED, 32'h12345678);
        rd_chk("R12 wrong feed", A_COUNT, 32'h7FFFFFFF);
        rd_chk("R12 wrong feed relocks", A_KEY, 32'h0);
        unlock_wr(A_FEED, FEED);
        rd_chk("R12 feed clears", A_COUNT, 32'h0);

        do_reset();

        // R6 always-run
        unlock_wr(A_CFG, 32'h1000);
        count_delta("R6 always run", 5, 5);

        // R7 run-while-awake
        core_in_reset = 1'b1;
        unlock_wr(A_CFG, 32'h2000);
        count_delta("R7 held asleep", 4, 0);
        core_in_reset = 1'b0;
        count_delta("R7 awake", 4, 4);

        // R8 scale window
        unlock_wr(A_CFG, 32'h4);
        unlock_wr(A_COUNT, 32'h00123456);
        rd_chk("R8 scale 4", A_SCALED, 32'h2345);
        unlock_wr(A_CFG, 32'hF);
        unlock_wr(A_COUNT, 32'h40008000);
        rd_chk("R8 scale 15", A_SCALED, 32'h8001);

        // R9 threshold flag
        unlock_wr(A_COUNT, 32'hF);
        unlock_wr(A_CFG, 32'h0);
        unlock_wr(A_CMP, 32'h10);
        expect_item("R9 below threshold", 1, 32'h0);
        unlock_wr(A_COUNT, 32'h10);
        expect_item("R9 not yet registered", 1, 32'h0);
        step();
        expect_item("R9 irq set", 1, 32'h1);
        rd_chk("R9 flag in cfg", A_CFG, 32'h10000000);
        expect_item("R10 no reset when disabled", 2, 32'h0);
        unlock_wr(A_FEED, FEED);
        unlock_wr(A_CFG, 32'h0);
        expect_item("R9 irq cleared", 1, 32'h0);
        rd_chk("R9 cfg cleared", A_CFG, 32'h0);

        // R10 reset request
        unlock_wr(A_CFG, 32'h100);
        expect_item("R10 idle", 2, 32'h0);
        unlock_wr(A_COUNT, 32'h20);
        step();
        expect_item("R10 raised", 2, 32'h1);
        unlock_wr(A_FEED, FEED);
        step();
        step();
        expect_item("R10 sticky", 2, 32'h1);

        do_reset();
        expect_item("R1 reset clears request", 2, 32'h0);

        // R11 zero on match
        unlock_wr(A_CMP, 32'h8);
        unlock_wr(A_CFG, 32'h200);
        unlock_wr(A_COUNT, 32'h8);
        rd_chk("R11 loaded", A_COUNT, 32'h8);
        step();
        rd_chk("R11 cleared", A_COUNT, 32'h0);
        expect_item("R11 flag set", 1, 32'h1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule